// File: doc/BRIEF.md
# Flash Controller Register Front End

This block is the software-facing side of an on-chip flash controller. It sits on a plain 32-bit register bus with single-cycle writes and combinational reads, and it holds three registers: a key register, a status register and a control register. After reset the control register is locked. Software opens it by writing two fixed key words in a fixed order. Once it is open, software can choose programming, sector erase or mass erase, pick a sector number and a program-size code, and launch the operation by setting the start bit.

The block does not contain flash cells. It drives a one-cycle strobe for each kind of operation, together with the sector number, the program-size code and the start address of the chosen sector, towards a stubbed array. The array's operation time is modelled by a busy timer of a configurable length. The sector map is not uniform. From the flash base it has four 16 KB sectors, then one 64 KB sector, then seven 128 KB sectors. A sector code outside 0 to 11 raises a sticky error flag and launches nothing. Software re-locks the control register by writing its lock bit. A key written out of order jams the lock until the next reset.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the control register reads 0x80000000: bit 31 (lock) is set and all fields are zero. The status register reads 0, and no strobe is active.
- R2: Writing 0x45670123 and then 0xCDEF89AB to the key register (offset 0x04) unlocks the controller, and control bit 31 then reads 0. Key writes made while the controller is unlocked are ignored, and the key register reads 0.
- R3: A key write with the wrong value for its step (including the second key written first) jams the controller locked until reset. Later correct key pairs have no effect.
- R4: While the controller is locked, control writes change no field and launch nothing.
- R5: A control write with bit 31 set re-locks an unlocked controller. The field values in that same write are still taken. A later correct key pair unlocks the controller again.
- R6: Control fields (offset 0x10) are: bit 0 program, bit 1 sector erase, bit 2 mass erase, bits 6:3 sector number, and bits 9:8 program size (2 = 32-bit). They read back at those positions and drive fl_sector and fl_psize.
- R7: A write with start (bit 16) set, issued while the controller is unlocked and idle, gives one-cycle strobes by priority. Mass erase wins over sector erase, and sector erase wins over program. fl_mass_pulse is high in the cycle after the write.
- R8: Start with sector erase selected (and mass erase clear) and a sector of 11 or less gives a one-cycle fl_erase_pulse in the cycle after the write.
- R9: Start with sector erase selected (and mass erase clear) and a sector above 11 sets status bit 7 (error). It gives no strobe and no busy. Writing 1 to status bit 7 (offset 0x0C) clears it.
- R10: Status bit 16 (busy) reads 1 for exactly BUSY_CYCLES cycles, beginning the cycle after a launching write.
- R11: A start written while busy launches nothing and does not lengthen the busy window.
- R12: Start with only program selected gives a one-cycle fl_prog_pulse in the cycle after the write.
- R13: For sectors 0 to 11, fl_sector_addr is the sector start. That start is base + n*16K for n<4, base + 64K for n=4, and base + (n-4)*128K for n>4, with base 0x08000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fl_prog_pulse | output | 1 | One-cycle program launch |
| fl_erase_pulse | output | 1 | One-cycle sector-erase launch |
| fl_mass_pulse | output | 1 | One-cycle mass-erase launch |
| fl_sector | output | 4 | Selected sector number |
| fl_psize | output | 2 | Program-size code |
| fl_sector_addr | output | 32 | Start address of the selected sector |

## Verification
The bench builds the block with BUSY_CYCLES set to 5 and keeps the other defaults. This makes the end of the busy window short enough to probe cycle by cycle. It also puts start requests in the last busy cycle and in the first idle cycle within a few writes of each other. With the default twelve-sector map, a sweep of all sixteen sector codes covers every region boundary and the invalid codes 12 to 15.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam logic [7:0]  OFF_KEY  = 8'h04;
    localparam logic [7:0]  OFF_STAT = 8'h0C;
    localparam logic [7:0]  OFF_CTRL = 8'h10;
    localparam logic [31:0] KEY_FIRST  = 32'h4567_0123;
    localparam logic [31:0] KEY_SECOND = 32'hCDEF_89AB;
    localparam int BIT_PG    = 0;
    localparam int BIT_SER   = 1;
    localparam int BIT_MER   = 2;
    localparam int SNB_LO    = 3;
    localparam int PSZ_LO    = 8;
    localparam int BIT_START = 16;
    localparam int BIT_LOCK  = 31;
    localparam int BIT_ERR   = 7;
    localparam int BIT_BUSY  = 16;

    typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN, KS_JAMMED} kstate_e;

    typedef struct packed {
        logic       pg;
        logic       ser;
        logic       mer;
        logic [3:0] snb;
        logic [1:0] psize;
    } ctrl_t;
endpackage

// File: rtl/fc_unlock.sv
module fc_unlock
    import fc_pkg::*;
#(
    parameter logic [31:0] KEY_A = KEY_FIRST,
    parameter logic [31:0] KEY_B = KEY_SECOND
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    input  logic        relock,
    output logic        locked
);
    typedef struct packed { kstate_e ks; } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ks)
            KS_LOCKED: if (key_wr) st_d.ks = (key_val == KEY_A) ? KS_HALF : KS_JAMMED;
            KS_HALF:   if (key_wr) st_d.ks = (key_val == KEY_B) ? KS_OPEN : KS_JAMMED;
            KS_OPEN:   if (relock) st_d.ks = KS_LOCKED;
            default:   st_d.ks = KS_JAMMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ks: KS_LOCKED};
        else        st_q <= st_d;
    end

    assign locked = (st_q.ks != KS_OPEN);

    // R3: a jammed lock stays jammed
    a_r3_jam_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ks == KS_JAMMED |=> st_q.ks == KS_JAMMED);
    // R2: opening only follows the half-keyed state
    a_r2_open_from_half: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ks == KS_LOCKED) |=> st_q.ks != KS_OPEN);
endmodule

// File: rtl/fc_busy_timer.sv
module fc_busy_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    typedef struct packed { logic [CW-1:0] cnt; } st_t;
    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch)               st_d.cnt = CW'(CYCLES);
        else if (st_q.cnt != '0)  st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

    // R10: a launch is followed by busy
    a_r10_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
    // R11: the front end never relaunches a running timer
    a_r11_no_launch_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);
endmodule

// File: rtl/fc_sector_map.sv
module fc_sector_map #(
    parameter logic [31:0] BASE        = 32'h0800_0000,
    parameter int          SMALL_CNT   = 4,
    parameter int          SMALL_BYTES = 16 * 1024,
    parameter int          MID_BYTES   = 64 * 1024,
    parameter int          LARGE_BYTES = 128 * 1024
) (
    input  logic [3:0]  sector,
    output logic [31:0] start_addr
);
    localparam logic [31:0] MID_START   = 32'(SMALL_CNT * SMALL_BYTES);
    localparam logic [31:0] LARGE_START = MID_START + 32'(MID_BYTES);

    logic [31:0] offset;
    always_comb begin
        if (int'(sector) < SMALL_CNT)
            offset = 32'(sector) * 32'(SMALL_BYTES);
        else if (int'(sector) == SMALL_CNT)
            offset = MID_START;
        else
            offset = LARGE_START + (32'(sector) - 32'(SMALL_CNT + 1)) * 32'(LARGE_BYTES);
        start_addr = BASE + offset;
    end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
    import fc_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          BUSY_CYCLES = 64,
    parameter int          NUM_SECTORS = 12,
    parameter logic [31:0] FLASH_BASE  = 32'h0800_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              fl_prog_pulse,
    output logic              fl_erase_pulse,
    output logic              fl_mass_pulse,
    output logic [3:0]        fl_sector,
    output logic [1:0]        fl_psize,
    output logic [31:0]       fl_sector_addr
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  err;
        logic  prog_p;
        logic  erase_p;
        logic  mass_p;
    } st_t;
    st_t st_d, st_q;

    logic locked, busy, launch, relock;
    logic key_wr, stat_wr, ctrl_wr;

    assign key_wr  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_KEY));
    assign stat_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_STAT));
    assign ctrl_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_CTRL));

    always_comb begin
        st_d         = st_q;
        st_d.prog_p  = 1'b0;
        st_d.erase_p = 1'b0;
        st_d.mass_p  = 1'b0;
        launch       = 1'b0;
        relock       = 1'b0;
        if (stat_wr && bus_wdata[BIT_ERR]) st_d.err = 1'b0;
        if (ctrl_wr && !locked) begin
            st_d.ctrl.pg    = bus_wdata[BIT_PG];
            st_d.ctrl.ser   = bus_wdata[BIT_SER];
            st_d.ctrl.mer   = bus_wdata[BIT_MER];
            st_d.ctrl.snb   = bus_wdata[SNB_LO +: 4];
            st_d.ctrl.psize = bus_wdata[PSZ_LO +: 2];
            relock          = bus_wdata[BIT_LOCK];
            if (bus_wdata[BIT_START] && !busy) begin
                if (bus_wdata[BIT_MER]) begin
                    st_d.mass_p = 1'b1;
                    launch      = 1'b1;
                end else if (bus_wdata[BIT_SER]) begin
                    if (int'(bus_wdata[SNB_LO +: 4]) >= NUM_SECTORS) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.erase_p = 1'b1;
                        launch       = 1'b1;
                    end
                end else if (bus_wdata[BIT_PG]) begin
                    st_d.prog_p = 1'b1;
                    launch      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fc_unlock u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (bus_wdata),
        .relock  (relock),
        .locked  (locked)
    );

    fc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy)
    );

    fc_sector_map #(.BASE(FLASH_BASE)) u_map (
        .sector     (st_q.ctrl.snb),
        .start_addr (fl_sector_addr)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL)) begin
            bus_rdata[BIT_LOCK]       = locked;
            bus_rdata[BIT_PG]         = st_q.ctrl.pg;
            bus_rdata[BIT_SER]        = st_q.ctrl.ser;
            bus_rdata[BIT_MER]        = st_q.ctrl.mer;
            bus_rdata[SNB_LO +: 4]    = st_q.ctrl.snb;
            bus_rdata[PSZ_LO +: 2]    = st_q.ctrl.psize;
        end else if (bus_addr == ADDR_W'(OFF_STAT)) begin
            bus_rdata[BIT_BUSY] = busy;
            bus_rdata[BIT_ERR]  = st_q.err;
        end
    end

    assign fl_prog_pulse  = st_q.prog_p;
    assign fl_erase_pulse = st_q.erase_p;
    assign fl_mass_pulse  = st_q.mass_p;
    assign fl_sector      = st_q.ctrl.snb;
    assign fl_psize       = st_q.ctrl.psize;

    // R7: at most one strobe at a time
    a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_prog_pulse, fl_erase_pulse, fl_mass_pulse}));
    // R10: every strobe comes with busy
    a_r10_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog_pulse || fl_erase_pulse || fl_mass_pulse) |-> busy);
    // R11: no strobe when the previous cycle was busy
    a_r11_idle_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_prog_pulse || fl_erase_pulse || fl_mass_pulse) |-> !$past(busy));
    // R9: a raised error never comes with a strobe
    a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> !(fl_prog_pulse || fl_erase_pulse || fl_mass_pulse));
    // R4: locked control writes leave the driven fields alone
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ctrl_wr) |=> ($stable(fl_sector) && $stable(fl_psize)));
endmodule

// File: tb/sim_flash_ctl_regs.sv
module sim_flash_ctl_regs;
    localparam int BUSY = 5;
    localparam logic [7:0] A_KEY = 8'h04, A_STAT = 8'h0C, A_CTRL = 8'h10;
    localparam logic [31:0] K1 = 32'h4567_0123, K2 = 32'hCDEF_89AB;

    logic clk = 0, rst_n = 0;
    logic bus_sel = 0, bus_we = 0;
    logic [7:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, fl_sector_addr;
    logic fl_prog_pulse, fl_erase_pulse, fl_mass_pulse;
    logic [3:0] fl_sector;
    logic [1:0] fl_psize;

    always #10 clk = ~clk;

    flash_ctl_regs #(.BUSY_CYCLES(BUSY)) u0 (.*);

    int vectors = 0, miscompares = 0;
    string cur_tag = "R1";

    // behavioural reference: 0 locked, 1 half, 2 open, 3 jammed
    int m_ks, m_cnt;
    bit m_pg, m_ser, m_mer, m_err, m_pp, m_ep, m_mp;
    int m_snb, m_psz;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ks = 0; m_cnt = 0; m_pg = 0; m_ser = 0; m_mer = 0; m_err = 0;
            m_snb = 0; m_psz = 0; m_pp = 0; m_ep = 0; m_mp = 0;
        end else begin
            bit was_busy;
            was_busy = (m_cnt != 0);
            m_pp = 0; m_ep = 0; m_mp = 0;
            if (m_cnt > 0) m_cnt--;
            if (bus_sel && bus_we) begin
                if (bus_addr == A_KEY) begin
                    if (m_ks == 0) m_ks = (bus_wdata == K1) ? 1 : 3;
                    else if (m_ks == 1) m_ks = (bus_wdata == K2) ? 2 : 3;
                end
                if (bus_addr == A_STAT && bus_wdata[7]) m_err = 0;
                if (bus_addr == A_CTRL && m_ks == 2) begin
                    m_pg = bus_wdata[0]; m_ser = bus_wdata[1]; m_mer = bus_wdata[2];
                    m_snb = int'(bus_wdata[6:3]); m_psz = int'(bus_wdata[9:8]);
                    if (bus_wdata[16] && !was_busy) begin
                        if (m_mer) begin m_mp = 1; m_cnt = BUSY; end
                        else if (m_ser) begin
                            if (m_snb > 11) m_err = 1;
                            else begin m_ep = 1; m_cnt = BUSY; end
                        end else if (m_pg) begin m_pp = 1; m_cnt = BUSY; end
                    end
                    if (bus_wdata[31]) m_ks = 0;
                end
            end
        end
    end

    function automatic logic [31:0] exp_addr(int n);
        int kb;
        if (n < 4) kb = n * 16;
        else if (n == 4) kb = 64;
        else kb = (n - 4) * 128;
        return 32'h0800_0000 + 32'(kb * 1024);
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r = 0;
        if (bus_addr == A_CTRL) begin
            r[31] = (m_ks != 2); r[0] = m_pg; r[1] = m_ser; r[2] = m_mer;
            r[6:3] = 4'(m_snb); r[9:8] = 2'(m_psz);
        end else if (bus_addr == A_STAT) begin
            r[16] = (m_cnt != 0); r[7] = m_err;
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, bus_rdata, exp_rdata());
        chk("R7 mass strobe", 32'(fl_mass_pulse), 32'(m_mp));
        chk("R8 erase strobe", 32'(fl_erase_pulse), 32'(m_ep));
        chk("R12 program strobe", 32'(fl_prog_pulse), 32'(m_pp));
        chk("R6 sector out", 32'(fl_sector), 32'(m_snb));
        chk("R6 psize out", 32'(fl_psize), 32'(m_psz));
        if (m_snb <= 11) chk("R13 sector start", fl_sector_addr, exp_addr(m_snb));
    endtask

    task automatic cyc(bit sel, bit we, logic [7:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        compare_all();
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; cur_tag = tag;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
        cyc(1, 1, a, d, tag);
    endtask

    task automatic rd(logic [7:0] a, string tag);
        cyc(1, 0, a, 0, tag);
    endtask

    task automatic idle(int n, logic [7:0] a, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, a, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        bus_sel = 0; bus_we = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    bit done = 0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++; vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values
        rd(A_CTRL, "R1 reset ctrl"); rd(A_STAT, "R1 reset status");
        // R4: locked writes ignored
        wr(A_CTRL, 32'h0001_0203, "R4 locked write"); rd(A_CTRL, "R4 locked readback");
        idle(2, A_STAT, "R4 no busy while locked");
        // R2: ordered unlock
        wr(A_KEY, K1, "R2 key1"); rd(A_CTRL, "R2 half keyed");
        wr(A_KEY, K2, "R2 key2"); rd(A_CTRL, "R2 unlocked");
        wr(A_KEY, 32'h1234_5678, "R2 key ignored when open"); rd(A_KEY, "R2 key reads zero");
        rd(A_CTRL, "R2 still open");
        // R6: field positions
        wr(A_CTRL, 32'h0000_022D, "R6 fields"); rd(A_CTRL, "R6 readback");
        // R8 / R10 / R11: sector erase, busy window, start while busy
        wr(A_CTRL, 32'h0001_022A, "R8 erase start");
        rd(A_STAT, "R10 busy");
        wr(A_CTRL, 32'h0001_0004, "R11 start while busy");
        idle(2, A_STAT, "R10 busy hold");
        wr(A_CTRL, 32'h0001_0001, "R11 start in last busy cycle");
        rd(A_STAT, "R10 busy ends");
        idle(2, A_STAT, "R10 idle");
        // R7: priority mass over sector over program
        wr(A_CTRL, 32'h0001_0007, "R7 mass start");
        idle(BUSY + 1, A_STAT, "R10 mass busy");
        // R12: program only
        wr(A_CTRL, 32'h0001_0201, "R12 program start");
        idle(BUSY + 1, A_STAT, "R10 program busy");
        // R8 priority sector over program
        wr(A_CTRL, 32'h0001_005B, "R8 erase over program");
        idle(BUSY + 1, A_STAT, "R10 erase busy");
        // R9: invalid sector
        wr(A_CTRL, 32'h0001_006A, "R9 bad sector");
        rd(A_STAT, "R9 error set");
        wr(A_CTRL, 32'h0001_007A, "R9 sector 15");
        rd(A_STAT, "R9 error held");
        wr(A_STAT, 32'h0000_0080, "R9 clear");
        rd(A_STAT, "R9 error cleared");
        // R13: sweep every sector code
        for (int s = 0; s < 16; s++) begin
            wr(A_CTRL, 32'(s) << 3, "R13 sweep");
            rd(A_CTRL, "R13 sweep readback");
        end
        // R5: relock with fields, ignored writes, reopen
        wr(A_CTRL, 32'h8000_0110, "R5 relock");
        rd(A_CTRL, "R5 locked");
        wr(A_CTRL, 32'h0001_0004, "R5 start while locked");
        rd(A_STAT, "R5 no launch");
        wr(A_KEY, K1, "R5 key1"); wr(A_KEY, K2, "R5 key2");
        rd(A_CTRL, "R5 reopened");
        // R3: wrong order jams
        wr(A_CTRL, 32'h8000_0000, "R3 relock");
        wr(A_KEY, K2, "R3 key2 first");
        wr(A_KEY, K1, "R3 key1 after jam"); wr(A_KEY, K2, "R3 key2 after jam");
        rd(A_CTRL, "R3 still locked");
        wr(A_CTRL, 32'h0001_0004, "R3 start when jammed");
        rd(A_STAT, "R3 no launch");
        do_reset();
        rd(A_CTRL, "R1 after reset");
        wr(A_KEY, K1, "R3 key1 after reset"); wr(A_KEY, 32'h0, "R3 bad second key");
        wr(A_KEY, K2, "R3 key2 late");
        rd(A_CTRL, "R3 jammed by bad second");
        idle(2, A_CTRL, "R3 final");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule